// File: doc/BRIEF.md
# Programmable CRC Checking Engine

This engine computes a cyclic redundancy check over blocks of 32-bit words. Software picks the polynomial through a small configuration port. The port offers three choices: a 16-bit preset, a 32-bit preset, or a custom setting. The custom setting takes its polynomial, initial value, final XOR mask, width and input/output bit-reflection options from the port. Each block carries its own length in words. A start pulse begins a block and captures the whole configuration, including the signature the result is to be compared against.

Words reach the engine from one of two sources:

- **Pass-through mode.** The engine watches a valid/ready word stream between a peripheral and memory. It only listens to that stream and has no output that could slow it.
- **Memory mode.** The engine walks a block in memory by itself, through a simple read port, starting from a base word address.

Inside, one byte is folded into the CRC per clock, least significant byte of each word first. A short word buffer absorbs snooped bursts. At the end of a block the engine raises a done flag and holds it, together with the final result and a match flag, until the next start.

Top module: `crc_engine`

## Requirements
- R1: With `cfg_sel` = 1 the engine uses polynomial 0x04C11DB7, initial value 0xFFFFFFFF, reflected input bytes, a reflected 32-bit output and a final XOR of 0xFFFFFFFF.
- R2: With `cfg_sel` = 0 the engine uses polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final XOR. The result occupies bits 15:0 and bits 31:16 read zero.
- R3: With `cfg_sel` = 2 or 3 the engine takes the following from the configuration port: polynomial, initial value, final XOR, input reflection, output reflection, and width (`cfg_wide` = 1 for 32 bits, 0 for 16 bits). Each reflection option applies independently of the other.
- R4: Each word is hashed as four bytes, bits 7:0 first and bits 31:24 last.
- R5: A block is exactly `blk_len` words long. A length of zero gives done with the result equal to the initial value after the output reflection and final XOR.
- R6: In pass-through mode a word is taken on each clock where `pt_valid` and `pt_ready` are both high. A cycle with only one of them high takes nothing. A burst of up to five back-to-back words is absorbed without loss.
- R7: In memory mode the engine reads addresses `mem_base`, `mem_base`+1, … in ascending order, issuing exactly `blk_len` reads. It never has more than one read outstanding, and it uses read data one cycle after `mem_rd_en`.
- R8: `crc_done` rises once the last word has been hashed. It then stays high, with `crc_result` unchanged, until the next `start`.
- R9: `crc_match` is high only while `crc_done` is high and the result equals the captured expected value, masked to the selected width.
- R10: Configuration, expected value, source, length and base are captured at `start`. Later changes to those ports do not affect the running block.
- R11: The following are ignored and do not change the result:
  - stream beats while no block is running;
  - stream beats beyond the block length;
  - stream beats during a memory-mode block.
- R12: A `start` during a running block abandons that block, drops `crc_done` on the following cycle, and runs the new block alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a block and captures the configuration |
| src_mem | input | 1 | Source select: 1 memory mode, 0 pass-through mode |
| cfg_sel | input | 2 | 0 16-bit preset, 1 32-bit preset, 2/3 custom |
| cfg_poly | input | 32 | Custom polynomial (low 16 bits in 16-bit width) |
| cfg_init | input | 32 | Custom initial value |
| cfg_xorout | input | 32 | Custom final XOR mask |
| cfg_refin | input | 1 | Custom: reflect each input byte |
| cfg_refout | input | 1 | Custom: reflect the result |
| cfg_wide | input | 1 | Custom: 1 for 32-bit, 0 for 16-bit |
| cfg_expect | input | 32 | Expected signature for the match flag |
| blk_len | input | LEN_W | Block length in words |
| mem_base | input | ADDR_W | First word address in memory mode |
| pt_valid | input | 1 | Observed stream valid |
| pt_ready | input | 1 | Observed stream ready |
| pt_data | input | WORD_W | Observed stream data |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read word address |
| mem_rd_data | input | WORD_W | Read data, valid one cycle after the request |
| crc_result | output | 32 | Final CRC value |
| crc_done | output | 1 | Block complete, held until next start |
| crc_match | output | 1 | Result equals the expected signature |

## Verification
The bench builds the engine with its default parameters: 32-bit words, 16-bit addresses and lengths, and a four-word snoop buffer. With these values a five-word back-to-back burst fills the buffer exactly, so the no-loss limit of the pass-through path is exercised at its edge. The 16-bit address and length widths let short blocks at non-zero bases show the ascending read order of memory mode. The default word width gives four byte steps per word, which makes byte order, mid-block restarts and zero-length blocks observable within a few dozen cycles.

// File: rtl/crc_eng_pkg.sv
// Package: shared types and pure functions for the CRC engine.
// Assumes a maximum CRC width of 32 bits; 16-bit operation uses bits 15:0.
package crc_eng_pkg;

    typedef enum logic [1:0] {
        SEL_CRC16  = 2'd0,
        SEL_CRC32  = 2'd1,
        SEL_CUSTOM = 2'd2
    } crc_sel_e;

    typedef struct packed {
        logic [31:0] poly;
        logic [31:0] init;
        logic [31:0] xorout;
        logic        refin;
        logic        refout;
        logic        wide;
    } crc_cfg_t;

    // Reverse the bit order of a byte.
    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // Reverse the bit order of a halfword.
    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    // Reverse the bit order of a word.
    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    // Fold one byte, most significant bit first, into the CRC state.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b,
                                             input logic [31:0] poly, input logic wide);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = (wide ? r[31] : r[15]) ^ b[7-i];
            r  = r << 1;
            if (fb) r = r ^ poly;
        end
        if (!wide) r[31:16] = 16'h0;
        return r;
    endfunction

    // Apply output reflection, final XOR and width mask.
    function automatic logic [31:0] crc_final(input logic [31:0] c, input logic refout,
                                              input logic [31:0] xorout, input logic wide);
        logic [31:0] v;
        if (refout) v = wide ? rev32(c) : {16'h0, rev16(c[15:0])};
        else        v = c;
        v = v ^ xorout;
        if (!wide) v[31:16] = 16'h0;
        return v;
    endfunction

    // Turn the configuration port into an effective setting.
    function automatic crc_cfg_t crc_resolve(input logic [1:0] sel, input logic [31:0] poly,
                                             input logic [31:0] init, input logic [31:0] xorout,
                                             input logic refin, input logic refout,
                                             input logic wide);
        crc_cfg_t c;
        case (sel)
            SEL_CRC16: c = '{poly: 32'h0000_1021, init: 32'h0000_FFFF, xorout: 32'h0,
                             refin: 1'b0, refout: 1'b0, wide: 1'b0};
            SEL_CRC32: c = '{poly: 32'h04C1_1DB7, init: 32'hFFFF_FFFF, xorout: 32'hFFFF_FFFF,
                             refin: 1'b1, refout: 1'b1, wide: 1'b1};
            default:   c = '{poly: poly, init: init, xorout: xorout,
                             refin: refin, refout: refout, wide: wide};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/crc_word_fifo.sv
// Module: small synchronous word buffer between the word sources and the hasher.
// Assumes the writer never pushes while full; a push when full is dropped.
module crc_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = store[rd_ptr];

    // Next pointer position with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Data storage write.
    always_ff @(posedge clk) begin
        if (push_ok && !clear) store[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/crc_byte_hasher.sv
// Module: splits buffered words into bytes (least significant first) and folds
// one byte per clock into the CRC state. A word is loaded on the cycle that
// finishes the previous one, so back-to-back words cost WORD_W/8 cycles each.
// Assumes poly/refin/wide are stable while a block runs.
module crc_byte_hasher #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [31:0]       init_val,
    input  logic [31:0]       poly,
    input  logic              refin,
    input  logic              wide,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    output logic              pop,
    output logic              word_done,
    output logic [31:0]       crc_state
);
    import crc_eng_pkg::*;

    localparam int NB = WORD_W / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    logic [WORD_W-1:0] word_q;
    logic [IW-1:0]     idx;
    logic              busy;
    logic [7:0]        cur_byte, feed_byte;
    logic [31:0]       crc_q;

    assign cur_byte  = word_q[{idx, 3'b000} +: 8];
    assign feed_byte = refin ? rev8(cur_byte) : cur_byte;
    assign word_done = busy && (idx == LAST);
    assign pop       = (!busy || word_done) && !fifo_empty && !clear;
    assign crc_state = crc_q;

    // Byte sequencing and CRC state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx    <= '0;
            busy   <= 1'b0;
            crc_q  <= '0;
        end else if (clear) begin
            idx    <= '0;
            busy   <= 1'b0;
            crc_q  <= init_val;
        end else begin
            if (busy) begin
                crc_q <= crc_step(crc_q, feed_byte, poly, wide);
                idx   <= idx + IW'(1);
            end
            if (pop) begin
                word_q <= fifo_word;
                busy   <= 1'b1;
                idx    <= '0;
            end else if (word_done) begin
                busy   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/crc_mem_fetch.sv
// Module: walks a memory block from a base word address, one read at a time.
// Assumes read data returns exactly one cycle after the request.
module crc_mem_fetch #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic              enable,
    input  logic              fifo_full,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              push
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  issued;
    logic              pending;

    assign rd_en   = enable && !start && !pending && !fifo_full && (issued != len);
    assign rd_addr = addr_q;
    assign push    = pending;

    // Address walk and outstanding-read tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            issued  <= '0;
            pending <= 1'b0;
        end else if (start) begin
            addr_q  <= base;
            issued  <= '0;
            pending <= 1'b0;
        end else begin
            pending <= rd_en;
            if (rd_en) begin
                addr_q <= addr_q + ADDR_W'(1);
                issued <= issued + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/crc_engine.sv
// Module: top of the programmable CRC checking engine. Captures the block
// configuration at start, feeds words from the snooped stream or the memory
// walker into a buffer, hashes them a byte per clock and flags completion.
// Assumes snooped traffic averages no more than one word per WORD_W/8 cycles.
module crc_engine
    import crc_eng_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              src_mem,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_poly,
    input  logic [31:0]       cfg_init,
    input  logic [31:0]       cfg_xorout,
    input  logic              cfg_refin,
    input  logic              cfg_refout,
    input  logic              cfg_wide,
    input  logic [31:0]       cfg_expect,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic              pt_valid,
    input  logic              pt_ready,
    input  logic [WORD_W-1:0] pt_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic [31:0]       crc_result,
    output logic              crc_done,
    output logic              crc_match
);
    crc_cfg_t          eff_cfg;
    logic [31:0]       poly_q, xor_q, expect_q, crc_state, width_mask;
    logic              refin_q, refout_q, wide_q, src_mem_q;
    logic [LEN_W-1:0]  len_q, words_in, words_done;
    logic              active, done_q, block_end;
    logic              pt_take, fetch_push, fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic              word_done;
    logic [WORD_W-1:0] fifo_din, fifo_dout;

    assign eff_cfg = crc_resolve(cfg_sel, cfg_poly, cfg_init, cfg_xorout,
                                 cfg_refin, cfg_refout, cfg_wide);

    assign pt_take    = active && !src_mem_q && !start && pt_valid && pt_ready
                        && (words_in != len_q);
    assign fifo_push  = pt_take || fetch_push;
    assign fifo_din   = fetch_push ? mem_rd_data : pt_data;
    assign block_end  = active && (words_done == len_q);
    assign width_mask = wide_q ? 32'hFFFF_FFFF : 32'h0000_FFFF;

    assign crc_result = crc_final(crc_state, refout_q, xor_q, wide_q);
    assign crc_done   = done_q;
    assign crc_match  = done_q && (crc_result == (expect_q & width_mask));

    // Capture of per-block settings at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poly_q    <= '0;
            xor_q     <= '0;
            expect_q  <= '0;
            refin_q   <= 1'b0;
            refout_q  <= 1'b0;
            wide_q    <= 1'b0;
            src_mem_q <= 1'b0;
            len_q     <= '0;
        end else if (start) begin
            poly_q    <= eff_cfg.poly;
            xor_q     <= eff_cfg.xorout;
            expect_q  <= cfg_expect;
            refin_q   <= eff_cfg.refin;
            refout_q  <= eff_cfg.refout;
            wide_q    <= eff_cfg.wide;
            src_mem_q <= src_mem;
            len_q     <= blk_len;
        end
    end

    // Block progress and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            done_q     <= 1'b0;
            words_in   <= '0;
            words_done <= '0;
        end else if (start) begin
            active     <= 1'b1;
            done_q     <= 1'b0;
            words_in   <= '0;
            words_done <= '0;
        end else begin
            if (pt_take)   words_in   <= words_in + LEN_W'(1);
            if (word_done) words_done <= words_done + LEN_W'(1);
            if (block_end) begin
                active <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    crc_mem_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base      (mem_base),
        .len       (len_q),
        .enable    (active && src_mem_q),
        .fifo_full (fifo_full),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_addr),
        .push      (fetch_push)
    );

    crc_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    crc_byte_hasher #(.WORD_W(WORD_W)) u_hash (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .init_val   (eff_cfg.init),
        .poly       (poly_q),
        .refin      (refin_q),
        .wide       (wide_q),
        .fifo_empty (fifo_empty),
        .fifo_word  (fifo_dout),
        .pop        (fifo_pop),
        .word_done  (word_done),
        .crc_state  (crc_state)
    );
endmodule

// File: rtl/crc_engine_chk.sv
// Module: temporal checks on the CRC engine, attached by bind.
module crc_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        crc_done,
    input logic        crc_match,
    input logic [31:0] crc_result,
    input logic        mem_rd_en,
    input logic        active,
    input logic        fifo_push,
    input logic        fifo_full
);
    // R6: the snoop buffer is never written while full
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    // R9: match only alongside done
    p_match_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        crc_match |-> crc_done);

    // R8: done holds until a start
    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_done && !start) |=> crc_done);

    // R8: result frozen while done holds
    p_result_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_done && !start) |=> $stable(crc_result));

    // R12: start drops done on the next cycle
    p_start_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !crc_done);

    // R7: at most one read in flight
    p_one_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R7: reads only inside a running block
    p_reads_in_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> active);
endmodule

bind crc_engine crc_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .crc_done   (crc_done),
    .crc_match  (crc_match),
    .crc_result (crc_result),
    .mem_rd_en  (mem_rd_en),
    .active     (active),
    .fifo_push  (fifo_push),
    .fifo_full  (fifo_full)
);

// File: tb/crc_engine_bench.sv
module crc_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, src_mem = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_poly = '0, cfg_init = '0, cfg_xorout = '0, cfg_expect = '0;
    logic        cfg_refin = 1'b0, cfg_refout = 1'b0, cfg_wide = 1'b0;
    logic [15:0] blk_len = '0, mem_base = '0;
    logic        pt_valid = 1'b0, pt_ready = 1'b0;
    logic [31:0] pt_data = '0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [31:0] mem_rd_data = '0;
    logic [31:0] crc_result;
    logic        crc_done, crc_match;

    int compared = 0, mismatched = 0;
    logic [31:0] mem [64];
    logic [31:0] exp_res_q [$];
    logic        exp_m_q [$];
    string       exp_tag_q [$];
    logic [15:0] exp_addr = '0;
    int          rd_count = 0;
    logic        done_prev = 1'b0;

    always #5 clk = ~clk;

    crc_engine u_crc_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .src_mem(src_mem),
        .cfg_sel(cfg_sel), .cfg_poly(cfg_poly), .cfg_init(cfg_init),
        .cfg_xorout(cfg_xorout), .cfg_refin(cfg_refin), .cfg_refout(cfg_refout),
        .cfg_wide(cfg_wide), .cfg_expect(cfg_expect), .blk_len(blk_len),
        .mem_base(mem_base), .pt_valid(pt_valid), .pt_ready(pt_ready),
        .pt_data(pt_data), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .crc_result(crc_result),
        .crc_done(crc_done), .crc_match(crc_match)
    );

    // Memory model: data one cycle after the request.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr[5:0]];

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] bitrev(input logic [31:0] v, input int w);
        logic [31:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = v[w-1-i];
        return r;
    endfunction

    // Reference CRC from the requirements, two independent formulations.
    function automatic logic [31:0] model_crc(input int base, input int n, input logic [31:0] poly,
            input logic [31:0] init, input logic [31:0] xo, input logic refin,
            input logic refout, input logic wide);
        int w = wide ? 32 : 16;
        logic [31:0] mask = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        logic [31:0] c, rp, res;
        logic [7:0]  b;
        if (refin && refout) begin
            rp = bitrev(poly, w);
            c  = bitrev(init & mask, w);
            for (int k = 0; k < n; k++)
                for (int j = 0; j < 4; j++) begin
                    b = mem[base+k][8*j +: 8];
                    c = c ^ {24'h0, b};
                    for (int t = 0; t < 8; t++) c = c[0] ? ((c >> 1) ^ rp) : (c >> 1);
                end
            res = c;
        end else begin
            c = init & mask;
            for (int k = 0; k < n; k++)
                for (int j = 0; j < 4; j++) begin
                    b = mem[base+k][8*j +: 8];
                    if (refin) b = bitrev({24'h0, b}, 8);
                    c = c ^ ({24'h0, b} << (w - 8));
                    for (int t = 0; t < 8; t++)
                        c = c[w-1] ? (((c << 1) & mask) ^ (poly & mask)) : ((c << 1) & mask);
                end
            res = refout ? bitrev(c, w) : c;
        end
        return (res ^ xo) & mask;
    endfunction

    // Scoreboard monitor: compare on each rising done.
    always @(negedge clk) begin
        if (rst_n && crc_done && !done_prev) begin
            if (exp_res_q.size() == 0) begin
                check(1'b0, "R12 unexpected done", crc_result, 32'h0);
            end else begin
                logic [31:0] er;
                logic        em;
                string       et;
                er = exp_res_q.pop_front();
                em = exp_m_q.pop_front();
                et = exp_tag_q.pop_front();
                check(crc_result == er, {et, " result"}, crc_result, er);
                check(crc_match == em, {et, " R9 match"}, {31'h0, crc_match}, {31'h0, em});
            end
        end
        done_prev = crc_done;
    end

    // Memory address order monitor.
    always @(negedge clk) begin
        if (rst_n && mem_rd_en) begin
            if (mem_addr != exp_addr) begin
                mismatched++;
                $display("FAIL R7 address: actual %h expected %h", mem_addr, exp_addr);
            end
            exp_addr++;
            rd_count++;
        end
    end

    task automatic pulse_start(input logic [1:0] sel, input logic [31:0] poly,
            input logic [31:0] init, input logic [31:0] xo, input logic ri, input logic ro,
            input logic wd, input logic [31:0] expv, input logic use_mem,
            input int base, input int n);
        tick();
        cfg_sel = sel; cfg_poly = poly; cfg_init = init; cfg_xorout = xo;
        cfg_refin = ri; cfg_refout = ro; cfg_wide = wd; cfg_expect = expv;
        src_mem = use_mem; mem_base = 16'(base); blk_len = 16'(n);
        start = 1'b1;
        exp_addr = 16'(base); rd_count = 0;
        tick();
        start = 1'b0;
    endtask

    task automatic pt_send(input int base, input int n, input int gap, input logic stall);
        for (int k = 0; k < n; k++) begin
            pt_data = mem[base+k]; pt_valid = 1'b1; pt_ready = !stall;
            if (stall) begin tick(); pt_ready = 1'b1; end
            tick();
            pt_valid = 1'b0; pt_ready = 1'b0;
            repeat (gap) tick();
        end
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 3000 && !crc_done; i++) tick();
        check(crc_done, {tag, " R8 done reached"}, {31'h0, crc_done}, 32'h1);
        tick();
    endtask

    // Driver: push expectation, run one block. mode: 0 normal, 1 scramble cfg after start, 2 pass noise in memory mode.
    task automatic run_block(input string tag, input logic [1:0] sel, input logic [31:0] poly,
            input logic [31:0] init, input logic [31:0] xo, input logic ri, input logic ro,
            input logic wd, input logic want_match, input logic use_mem, input int base,
            input int n, input int gap, input logic stall, input int mode);
        logic [31:0] p = poly, iv = init, x = xo, model;
        logic r1 = ri, r2 = ro, w = wd;
        if (sel == 2'd0) begin p = 32'h1021; iv = 32'hFFFF; x = 0; r1 = 0; r2 = 0; w = 0; end
        if (sel == 2'd1) begin p = 32'h04C11DB7; iv = 32'hFFFFFFFF; x = 32'hFFFFFFFF;
                               r1 = 1; r2 = 1; w = 1; end
        model = model_crc(base, n, p, iv, x, r1, r2, w);
        exp_res_q.push_back(model);
        exp_m_q.push_back(want_match);
        exp_tag_q.push_back(tag);
        if (mode == 2) begin pt_valid = 1'b1; pt_ready = 1'b1; pt_data = 32'hDEADBEEF; end
        pulse_start(sel, poly, init, xo, ri, ro, wd, want_match ? model : ~model, use_mem, base, n);
        if (mode == 1) begin
            cfg_sel = 2'd2; cfg_poly = 32'h1234_5678; cfg_init = 32'h0; cfg_xorout = 32'h55;
            cfg_wide = 1'b0; cfg_refin = 1'b0; cfg_refout = 1'b1; cfg_expect = 32'h0;
            blk_len = 16'd1; src_mem = 1'b1; mem_base = 16'd0;
        end
        if (!use_mem) pt_send(base, n, gap, stall);
        wait_done(tag);
        pt_valid = 1'b0; pt_ready = 1'b0;
        if (use_mem) check(rd_count == n, {tag, " R7 read count"}, 32'(rd_count), 32'(n));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] held;
        for (int i = 0; i < 64; i++) mem[i] = (32'h9E3779B9 * (i + 1)) ^ (i << 7);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // Reset state (R8, R9)
        check(crc_done == 1'b0, "R8 reset done", {31'h0, crc_done}, 32'h0);
        check(crc_match == 1'b0, "R9 reset match", {31'h0, crc_match}, 32'h0);
        check(crc_result == 32'h0, "R8 reset result", crc_result, 32'h0);
        check(mem_rd_en == 1'b0, "R7 reset read", {31'h0, mem_rd_en}, 32'h0);

        // R11: idle beats before any start do nothing
        pt_valid = 1'b1; pt_ready = 1'b1; pt_data = 32'hFFFF0000;
        repeat (4) tick();
        pt_valid = 1'b0; pt_ready = 1'b0;
        check(crc_done == 1'b0 && crc_result == 32'h0, "R11 idle beats", crc_result, 32'h0);

        // R1 R4 R7: 32-bit preset, memory mode, matching signature
        run_block("R1 R4 R7", 2'd1, 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 8, 4, 0, 1'b0, 0);
        // R2 R6: 16-bit preset, pass-through with stalls, wrong signature
        run_block("R2 R6", 2'd0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 3, 3, 4, 1'b1, 0);
        check(crc_result[31:16] == 16'h0, "R2 upper bits", crc_result, {16'h0, crc_result[15:0]});
        // R3: custom 16-bit fully reflected, memory mode
        run_block("R3 ref16", 2'd2, 32'h8005, 32'h0, 32'h0, 1, 1, 0, 1'b1, 1'b1, 20, 5, 0, 1'b0, 0);
        // R3 R6: custom 32-bit output-only reflection, five-word burst
        run_block("R3 R6 burst", 2'd3, 32'h1EDC6F41, 32'h12345678, 32'hA5A5A5A5, 0, 1, 1,
                  1'b1, 1'b0, 30, 5, 0, 1'b0, 0);
        // R3: custom 16-bit input-only reflection
        run_block("R3 refin16", 2'd2, 32'h3D65, 32'hBEEF, 32'h0F0F, 1, 0, 0,
                  1'b1, 1'b0, 40, 4, 3, 1'b1, 0);
        // R5: zero-length block
        run_block("R5 empty", 2'd1, 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 0, 0, 0, 1'b0, 0);
        check(crc_result == 32'h0, "R5 empty value", crc_result, 32'h0);
        // R10: configuration scrambled after start
        run_block("R10 capture", 2'd1, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0, 12, 3, 4, 1'b0, 1);
        // R11: beats beyond length leave the result unchanged
        held = crc_result;
        pt_send(50, 3, 0, 1'b0);
        tick();
        check(crc_result == held && crc_done, "R11 extra beats", crc_result, held);
        // R11: stream noise during a memory block
        run_block("R11 noise", 2'd0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 44, 6, 0, 1'b0, 2);
        // R8: done and result held
        held = crc_result;
        repeat (20) tick();
        check(crc_done == 1'b1, "R8 done held", {31'h0, crc_done}, 32'h1);
        check(crc_result == held, "R8 result held", crc_result, held);
        // R12: restart mid-block; only the second block completes
        pulse_start(2'd1, 0, 0, 0, 0, 0, 0, 32'h0, 1'b1, 0, 8);
        check(crc_done == 1'b0, "R12 done dropped", {31'h0, crc_done}, 32'h0);
        repeat (6) tick();
        run_block("R12 restart", 2'd0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0, 16, 2, 3, 1'b0, 0);
        check(exp_res_q.size() == 0, "R8 all blocks seen", 32'(exp_res_q.size()), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule